// File: doc/BRIEF.md
# Transmit Endpoint Buffer with DMA Fill

This block sits between a DMA engine and the packet transmitter of a USB function, on an IN (device-to-host) bulk endpoint. It holds one packet of up to `MAX_PKT` bytes (64 by default). While the buffer is empty and DMA service is switched on, it requests data. The DMA engine then writes bytes one at a time. Each byte goes into the next free slot.

A packet becomes ready for transmission in one of two ways. When the last free slot is written, the packet commits by itself and the buffer reports full. A shorter packet waits until software issues a single-cycle packet-end command. Once a packet is committed, the transmitter reads it back through a byte pointer and receives the packet length. When the transmitter signals that transmission is complete, the buffer returns to empty and starts requesting data again. A write that arrives while a packet is committed is discarded and recorded in a sticky flag.

Top module: `txep_dma_fill`

## Requirements
- R1: After reset the buffer is empty, no packet is committed, `tx_len` is 0, `buf_full` and `wr_overflow` are 0, and `dma_req` equals `dma_en`.
- R2: `dma_req` is 1 exactly when `dma_en` is 1, the buffer holds no bytes and no packet is committed. It drops in the cycle after the first byte is accepted.
- R3: Each `dma_ack` cycle while no packet is committed stores `dma_data` (8 bits) in the next slot. The transmitter reads the bytes back in write order: `tx_data` shows the byte at the read pointer, and each `tx_rd` cycle advances the pointer by one.
- R4: The write that fills slot `MAX_PKT` commits the packet with no software action. In the cycle after that write, `tx_ready`=1, `buf_full`=1 and `tx_len`=`MAX_PKT`.
- R5: A packet shorter than `MAX_PKT` stays uncommitted (`tx_ready`=0) until `sw_pkt_end` is pulsed. In the cycle after the pulse, `tx_ready`=1 and `tx_len` equals the number of bytes written.
- R6: `sw_pkt_end` has no effect when the buffer is empty or a packet is already committed.
- R7: While a packet is committed and `tx_done` has not been given, `tx_len` and `tx_ready` hold their values. `tx_len` is 0 whenever no packet is committed.
- R8: `tx_done` while a packet is committed empties the buffer, so `dma_req` returns the next cycle. `tx_done` at any other time has no effect.
- R9: A `dma_ack` write while a packet is committed is dropped and leaves the stored bytes and `tx_len` unchanged. It sets `wr_overflow`, which stays set until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| dma_en | input | 1 | Enables DMA service requests |
| dma_req | output | 1 | Request for data while the buffer is empty |
| dma_ack | input | 1 | One byte write this cycle |
| dma_data | input | 8 | Byte written by the DMA engine |
| sw_pkt_end | input | 1 | Software command that commits a short packet |
| tx_rd | input | 1 | Transmitter advances the read pointer |
| tx_data | output | 8 | Byte at the read pointer |
| tx_len | output | 7 | Committed packet length, 0 when nothing is committed |
| tx_ready | output | 1 | A packet is committed and may be sent |
| tx_done | input | 1 | Transmitter finished the committed packet |
| buf_full | output | 1 | All `MAX_PKT` slots hold data |
| buf_empty | output | 1 | The buffer holds no bytes |
| wr_overflow | output | 1 | Sticky flag for a dropped write |

## Verification
A wrong byte count shows up on the cycle after a commit: `tx_len` differs from the number of writes, or `buf_full` fires at the wrong size. A wrong fill state shows up one cycle after the offending write, commit or done: `dma_req`, `tx_ready` or `buf_empty` changes too early, too late, or not at all. Corrupted storage or a wrong read pointer shows up as a mismatched `tx_data` byte during readback of the same packet. The bench sweeps every packet length from 1 to `MAX_PKT` with length-dependent data, so each of these faults is caught within one packet.

// File: rtl/txep_pkg.sv
package txep_pkg;
   localparam int unsigned TXEP_DEF_MAX = 64;

   typedef enum logic [1:0] {
      ST_EMPTY = 2'd0,
      ST_FILL  = 2'd1,
      ST_SENT  = 2'd2
   } txep_state_e;
endpackage

// File: rtl/txep_ctrl.sv
module txep_ctrl
   import txep_pkg::*;
#(
   parameter int unsigned MAX_PKT = TXEP_DEF_MAX,
   localparam int unsigned CW = $clog2(MAX_PKT + 1),
   localparam int unsigned AW = $clog2(MAX_PKT)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          dma_en,
   input  logic          dma_ack,
   input  logic          sw_pkt_end,
   input  logic          tx_done,
   output logic          dma_req,
   output logic          wr_en,
   output logic [AW-1:0] wr_addr,
   output logic          sent,
   output logic [CW-1:0] tx_len,
   output logic          buf_full,
   output logic          buf_empty,
   output logic          wr_overflow
);
   txep_state_e state_q, state_d;
   logic [CW-1:0] cnt_q, cnt_d;
   logic ovf_q;
   logic accept, drop;

   // Writes go in only while no packet is committed.
   assign accept = dma_ack && (state_q != ST_SENT);
   assign drop   = dma_ack && (state_q == ST_SENT);
   assign cnt_d  = accept ? cnt_q + CW'(1) : cnt_q;

   always_comb begin
      state_d = state_q;
      case (state_q)
         ST_EMPTY, ST_FILL: begin
            if (cnt_d == CW'(MAX_PKT))
               state_d = ST_SENT;
            else if (sw_pkt_end && cnt_d != '0)
               state_d = ST_SENT;
            else if (cnt_d != '0)
               state_d = ST_FILL;
         end
         ST_SENT: if (tx_done) state_d = ST_EMPTY;
         default: state_d = ST_EMPTY;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state_q <= ST_EMPTY;
         cnt_q   <= '0;
         ovf_q   <= 1'b0;
      end else begin
         state_q <= state_d;
         cnt_q   <= (state_q == ST_SENT && tx_done) ? '0 : cnt_d;
         if (drop) ovf_q <= 1'b1;
      end
   end

   assign wr_en       = accept;
   assign wr_addr     = cnt_q[AW-1:0];
   assign sent        = (state_q == ST_SENT);
   assign tx_len      = sent ? cnt_q : '0;
   assign buf_full    = (cnt_q == CW'(MAX_PKT));
   assign buf_empty   = (cnt_q == '0);
   assign dma_req     = dma_en && (state_q == ST_EMPTY);
   assign wr_overflow = ovf_q;

   // R4: the last free slot commits the packet
   p_auto_commit_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (dma_ack && !sent && cnt_q == CW'(MAX_PKT - 1)) |=> (sent && buf_full));
   // R6: end command on an empty buffer is ignored
   p_end_ignored_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (sw_pkt_end && buf_empty && !dma_ack && !sent) |=> !sent);
   // R7: length holds while committed
   p_len_stable_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (sent && !tx_done) |=> (sent && $stable(tx_len)));
   // R9: overflow flag is sticky
   p_ovf_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
      wr_overflow |=> wr_overflow);
   // R9: count never passes the packet size
   p_no_overflow_r9: assert property (@(posedge clk) disable iff (!rst_n)
      cnt_q <= CW'(MAX_PKT));
endmodule

// File: rtl/txep_store.sv
module txep_store #(
   parameter int unsigned MAX_PKT = 64,
   parameter int unsigned DW      = 8,
   parameter bit          OUT_REG = 1'b0,
   localparam int unsigned AW = $clog2(MAX_PKT)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          wr_en,
   input  logic [AW-1:0] wr_addr,
   input  logic [DW-1:0] wr_data,
   input  logic          sent,
   input  logic          tx_rd,
   input  logic          tx_done,
   output logic [DW-1:0] tx_data
);
   logic [DW-1:0] mem [MAX_PKT];
   logic [AW-1:0] rptr_q;

   always_ff @(posedge clk) begin
      if (wr_en) mem[wr_addr] <= wr_data;
   end

   always_ff @(posedge clk) begin
      if (!rst_n)                rptr_q <= '0;
      else if (sent && tx_done)  rptr_q <= '0;
      else if (sent && tx_rd)    rptr_q <= rptr_q + AW'(1);
   end

   generate
      if (OUT_REG) begin : g_out_reg
         logic [DW-1:0] dq;
         always_ff @(posedge clk) dq <= mem[rptr_q];
         assign tx_data = dq;
      end else begin : g_out_comb
         assign tx_data = mem[rptr_q];
      end
   endgenerate

   // R3: the read pointer moves only while a packet is committed
   p_rptr_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (!sent) |=> (rptr_q == '0 || $stable(rptr_q)));
endmodule

// File: rtl/txep_dma_fill.sv
module txep_dma_fill
   import txep_pkg::*;
#(
   parameter int unsigned MAX_PKT = TXEP_DEF_MAX,
   parameter bit          OUT_REG = 1'b0,
   localparam int unsigned DW = 8,
   localparam int unsigned CW = $clog2(MAX_PKT + 1),
   localparam int unsigned AW = $clog2(MAX_PKT)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          dma_en,
   output logic          dma_req,
   input  logic          dma_ack,
   input  logic [DW-1:0] dma_data,
   input  logic          sw_pkt_end,
   input  logic          tx_rd,
   output logic [DW-1:0] tx_data,
   output logic [CW-1:0] tx_len,
   output logic          tx_ready,
   input  logic          tx_done,
   output logic          buf_full,
   output logic          buf_empty,
   output logic          wr_overflow
);
   initial begin
      assert (MAX_PKT >= 2 && MAX_PKT <= 1024)
         else $error("MAX_PKT out of range");
      assert ((1 << AW) == MAX_PKT)
         else $error("MAX_PKT must be a power of two");
   end

   logic          wr_en;
   logic [AW-1:0] wr_addr;
   logic          sent;

   txep_ctrl #(.MAX_PKT(MAX_PKT)) u_ctrl (
      .clk(clk), .rst_n(rst_n), .dma_en(dma_en), .dma_ack(dma_ack),
      .sw_pkt_end(sw_pkt_end), .tx_done(tx_done), .dma_req(dma_req),
      .wr_en(wr_en), .wr_addr(wr_addr), .sent(sent), .tx_len(tx_len),
      .buf_full(buf_full), .buf_empty(buf_empty), .wr_overflow(wr_overflow)
   );

   txep_store #(.MAX_PKT(MAX_PKT), .DW(DW), .OUT_REG(OUT_REG)) u_store (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
      .wr_data(dma_data), .sent(sent), .tx_rd(tx_rd), .tx_done(tx_done),
      .tx_data(tx_data)
   );

   assign tx_ready = sent;

   // R2: a request only goes out for an empty, uncommitted buffer
   p_req_empty_r2: assert property (@(posedge clk) disable iff (!rst_n)
      dma_req |-> (buf_empty && !tx_ready));
   // R8: done on a committed packet empties the buffer
   p_done_clears_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (tx_ready && tx_done) |=> (buf_empty && !tx_ready));
endmodule

// File: tb/tb_txep_dma_fill.sv
module tb_txep_dma_fill;
   localparam int MAX = 64;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic dma_en = 1'b0, dma_ack = 1'b0, sw_pkt_end = 1'b0, tx_rd = 1'b0, tx_done = 1'b0;
   logic [7:0] dma_data = '0;
   logic dma_req, tx_ready, buf_full, buf_empty, wr_overflow;
   logic [7:0] tx_data;
   logic [6:0] tx_len;
   int checks = 0, errors = 0;
   bit finished = 1'b0;

   always #2.5 clk = ~clk;

   txep_dma_fill dut (
      .clk(clk), .rst_n(rst_n), .dma_en(dma_en), .dma_req(dma_req),
      .dma_ack(dma_ack), .dma_data(dma_data), .sw_pkt_end(sw_pkt_end),
      .tx_rd(tx_rd), .tx_data(tx_data), .tx_len(tx_len), .tx_ready(tx_ready),
      .tx_done(tx_done), .buf_full(buf_full), .buf_empty(buf_empty),
      .wr_overflow(wr_overflow)
   );

   task automatic chk(input string req, input int act, input int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   function automatic logic [7:0] pat(input int len, input int i);
      return 8'((len * 7 + i * 13 + 5) & 255);
   endfunction

   task automatic step();
      @(posedge clk);
      #1;
   endtask

   task automatic wr(input logic [7:0] d);
      dma_ack = 1'b1; dma_data = d;
      step();
      dma_ack = 1'b0;
   endtask

   task automatic pulse_end();
      sw_pkt_end = 1'b1; step(); sw_pkt_end = 1'b0;
   endtask

   task automatic pulse_done();
      tx_done = 1'b1; step(); tx_done = 1'b0;
   endtask

   initial begin
      step(); step();
      rst_n = 1'b1;
      #0;
      chk("R1 empty", buf_empty, 1);
      chk("R1 ready", tx_ready, 0);
      chk("R1 len", tx_len, 0);
      chk("R1 full", buf_full, 0);
      chk("R1 ovf", wr_overflow, 0);
      chk("R1 req follows en=0", dma_req, 0);
      dma_en = 1'b1; #1;
      chk("R1 req follows en=1", dma_req, 1);

      pulse_end();
      chk("R6 end on empty ignored", tx_ready, 0);
      chk("R6 end on empty req", dma_req, 1);
      pulse_done();
      chk("R8 done idle ignored", buf_empty, 1);

      for (int len = 1; len <= MAX; len++) begin
         chk("R2 req before fill", dma_req, 1);
         for (int i = 0; i < len; i++) begin
            wr(pat(len, i));
            if (i == 0) chk("R2 req drops", dma_req, 0);
            if (i < MAX - 1) chk("R5 not committed early", tx_ready, 0);
         end
         if (len < MAX) begin
            chk("R5 len zero before commit", tx_len, 0);
            pulse_end();
         end
         chk("R4/R5 committed", tx_ready, 1);
         chk("R4/R5 tx_len", tx_len, len);
         chk("R4 full", buf_full, (len == MAX) ? 1 : 0);
         pulse_end();
         chk("R6 end on committed len", tx_len, len);
         if (len == MAX) begin
            wr(8'hEE);
            chk("R9 ovf set", wr_overflow, 1);
            chk("R9 len kept", tx_len, len);
         end else begin
            chk("R9 ovf clear", wr_overflow, 0);
         end
         for (int i = 0; i < len; i++) begin
            chk("R3 data order", tx_data, pat(len, i));
            chk("R7 len stable", tx_len, len);
            tx_rd = 1'b1; step(); tx_rd = 1'b0;
         end
         chk("R7 still ready", tx_ready, 1);
         pulse_done();
         chk("R8 empty after done", buf_empty, 1);
         chk("R8 req back", dma_req, 1);
         chk("R7 len zero idle", tx_len, 0);
      end
      chk("R9 ovf sticky", wr_overflow, 1);
      finished = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!finished) begin
         checks++; errors++;
         $display("FAIL watchdog actual=0 expected=1");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end
endmodule